// File: doc/BRIEF.md
# Shared Timer/Watchdog Clock Prescaler

This block takes a stream of single-cycle input ticks and scales it down by a programmable power of two. Its output goes to one of two consumers: an 8-bit timer/counter or a watchdog timer. One byte-wide control register selects which consumer gets the divided stream and which of eight ratios applies. The consumer that is not selected still receives one enable pulse for every input tick.

For any given select code, the ratio depends on the assigned consumer. The timer divides by twice what the watchdog would for the same code. The watchdog at its smallest code therefore sees every tick.

Software rewrites the control byte through a single-cycle write strobe. A separate synchronous clear input restarts the divider, in the way a watchdog-clear operation does. Both actions restart counting from zero, so a reconfiguration can never produce a shortened first period.

Top module: `tmr_wdt_prescaler`

## Requirements
- R1: After reset, the control readback is 0xFF. The watchdog is then assigned at ratio 1:128: its first enable pulse comes on the 128th input tick.
- R2: Control bit 3 selects the assigned consumer. A value of 0 routes the divided stream to the timer enable and a value of 1 routes it to the watchdog enable.
- R3: With the timer assigned and select code N in control bits 2..0, the timer enable pulses on every 2^(N+1)-th tick: 1:2 at code 0 up to 1:256 at code 7.
- R4: With the watchdog assigned and select code N in bits 2..0, the watchdog enable pulses on every 2^N-th tick. Code 0 passes every tick through.
- R5: The unassigned consumer's enable is high in every cycle in which the input tick is high.
- R6: Neither enable is ever high in a cycle without an input tick, and each pulse lasts one cycle.
- R7: A control write restarts the divider. In the write cycle the assigned consumer gets no pulse and the tick in that cycle is not counted. The next pulse comes on the full-ratio-th tick after the write.
- R8: The synchronous clear input acts on the divider exactly as a write does in R7 and leaves the control byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Input tick stream, one cycle per tick |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte write data (bit 3 assignment, bits 2..0 select) |
| div_clr_i | input | 1 | Synchronous divider clear |
| ctrl_o | output | 8 | Current control byte |
| tmr_en_o | output | 1 | Enable pulse toward the timer/counter |
| wdt_en_o | output | 1 | Enable pulse toward the watchdog |

## Verification
A divider counter left holding a stale value shows up as a short first period. The assigned enable then fires before the full ratio of ticks has passed since the last write or clear, so it is visible within one period. A wrong rate decode or a swapped assignment changes the tick distance between pulses right away. The bench measures that distance for all sixteen combinations of assignment and code. A routing fault on the unassigned path drops a pulse on the very first tick.

// File: rtl/presc_pkg.sv
// Package: shared constants and types for the timer/watchdog prescaler.
// Assumes the divider is wide enough to hold the largest timer ratio.
package presc_pkg;
    localparam int CTRL_W   = 8;
    localparam int SEL_W    = 3;
    localparam int ASG_BIT  = 3;
    localparam int CNT_W    = 8;
    localparam logic [CTRL_W-1:0] CTRL_RST = 8'hFF;

    typedef enum logic {
        TGT_TIMER = 1'b0,
        TGT_WDOG  = 1'b1
    } presc_tgt_e;
endpackage

// File: rtl/presc_ctrl_reg.sv
// Control byte register. Holds assignment bit and rate select.
// Assumes a single-cycle write strobe; reset value assigns the watchdog at max rate.
module presc_ctrl_reg
    import presc_pkg::*;
#(
    parameter int W       = CTRL_W,
    parameter int SW      = SEL_W,
    parameter int ABIT    = ASG_BIT,
    parameter logic [W-1:0] RST_VAL = CTRL_RST
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  ctrl_q,
    output presc_tgt_e    tgt,
    output logic [SW-1:0] sel
);
    // Capture the control byte on write, default on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= RST_VAL;
        else if (we)
            ctrl_q <= wdata;
    end

    // Split the stored byte into its fields.
    always_comb begin
        tgt = presc_tgt_e'(ctrl_q[ABIT]);
        sel = ctrl_q[SW-1:0];
    end
endmodule

// File: rtl/presc_divider.sv
// Free-running tick counter forming the ripple divider.
// Assumes clr has priority over counting; wraps at 2^CW.
module presc_divider #(
    parameter int CW = presc_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    // Count input ticks, restarting on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/presc_rate_sel.sv
// Rate multiplexer: maps target and select code to a divider tap and
// flags the cycle where the low 'k' counter bits are all ones.
// Assumes CW >= 2^SW so the timer ratio for the top code fits.
module presc_rate_sel
    import presc_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int SW = SEL_W,
    localparam int KW = $clog2(CW + 1)
) (
    input  logic [CW-1:0] cnt,
    input  presc_tgt_e    tgt,
    input  logic [SW-1:0] sel,
    output logic          hit
);
    logic [CW:0]   tap_full;
    logic [KW-1:0] k;

    // Tap 0 is the undivided stream; tap j needs the low j bits at all ones.
    assign tap_full[0] = 1'b1;
    for (genvar j = 1; j <= CW; j++) begin : g_tap
        assign tap_full[j] = &cnt[j-1:0];
    end

    // Choose the exponent: watchdog uses the code, timer the code plus one.
    always_comb begin
        if (tgt == TGT_WDOG)
            k = KW'(sel);
        else
            k = KW'(sel) + KW'(1);
    end

    // Pick the selected tap.
    always_comb begin
        hit = tap_full[k];
    end
endmodule

// File: rtl/presc_route.sv
// Routes the divided pulse to the assigned consumer and the raw tick to the other.
// Assumes 'restart' suppresses the divided pulse in its own cycle.
module presc_route
    import presc_pkg::*;
(
    input  logic       tick,
    input  logic       hit,
    input  logic       restart,
    input  presc_tgt_e tgt,
    output logic       tmr_en,
    output logic       wdt_en
);
    logic div_pulse;

    // Form the enable outputs from the divided and raw streams.
    always_comb begin
        div_pulse = tick & hit & ~restart;
        if (tgt == TGT_WDOG) begin
            wdt_en = div_pulse;
            tmr_en = tick;
        end else begin
            tmr_en = div_pulse;
            wdt_en = tick;
        end
    end
endmodule

// File: rtl/tmr_wdt_prescaler.sv
// Top: shared prescaler for the timer/counter and watchdog.
// Assumes single-cycle ticks synchronous to clk and synchronous active-low reset.
module tmr_wdt_prescaler
    import presc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              ctrl_we_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    input  logic              div_clr_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              tmr_en_o,
    output logic              wdt_en_o
);
    presc_tgt_e       tgt;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] cnt;
    logic             hit;
    logic             restart;

    // A write or an explicit clear restarts the divider.
    always_comb begin
        restart = ctrl_we_i | div_clr_i;
    end

    presc_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ctrl_we_i),
        .wdata  (ctrl_wdata_i),
        .ctrl_q (ctrl_o),
        .tgt    (tgt),
        .sel    (sel)
    );

    presc_divider #(.CW(CNT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_i),
        .clr   (restart),
        .cnt   (cnt)
    );

    presc_rate_sel #(.CW(CNT_W), .SW(SEL_W)) u_rate (
        .cnt (cnt),
        .tgt (tgt),
        .sel (sel),
        .hit (hit)
    );

    presc_route u_route (
        .tick    (tick_i),
        .hit     (hit),
        .restart (restart),
        .tgt     (tgt),
        .tmr_en  (tmr_en_o),
        .wdt_en  (wdt_en_o)
    );
endmodule

// File: rtl/presc_chk.sv
// Checker for the prescaler top, attached by bind; observes ports only.
module presc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       ctrl_we_i,
    input logic       div_clr_i,
    input logic [7:0] ctrl_o,
    input logic       tmr_en_o,
    input logic       wdt_en_o
);
    // R1
    reset_default_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> ctrl_o == 8'hFF);

    // R6
    no_idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |-> (!tmr_en_o && !wdt_en_o));

    // R5
    wdt_side_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && ctrl_o[3]) |-> tmr_en_o);

    // R5
    tmr_side_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !ctrl_o[3]) |-> wdt_en_o);

    // R4
    wdt_unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && ctrl_o[3:0] == 4'b1000 && !ctrl_we_i && !div_clr_i) |-> wdt_en_o);

    // R3
    tmr_no_back2back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_en_o && !ctrl_o[3] && !ctrl_we_i) |=> !tmr_en_o);

    // R7
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we_i || div_clr_i) |-> (ctrl_o[3] ? !wdt_en_o : !tmr_en_o));
endmodule

bind tmr_wdt_prescaler presc_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .ctrl_we_i (ctrl_we_i),
    .div_clr_i (div_clr_i),
    .ctrl_o    (ctrl_o),
    .tmr_en_o  (tmr_en_o),
    .wdt_en_o  (wdt_en_o)
);

// File: tb/tmr_wdt_prescaler_tb.sv
module tmr_wdt_prescaler_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       ctrl_we_i = 1'b0;
    logic [7:0] ctrl_wdata_i = 8'h00;
    logic       div_clr_i = 1'b0;
    logic [7:0] ctrl_o;
    logic       tmr_en_o;
    logic       wdt_en_o;

    int n_chk = 0;
    int n_bad = 0;
    logic s_tmr, s_wdt;

    always #2.5 clk = ~clk;

    tmr_wdt_prescaler dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .ctrl_we_i    (ctrl_we_i),
        .ctrl_wdata_i (ctrl_wdata_i),
        .div_clr_i    (div_clr_i),
        .ctrl_o       (ctrl_o),
        .tmr_en_o     (tmr_en_o),
        .wdt_en_o     (wdt_en_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: drive after the falling edge, sample, then cross the rising edge.
    task automatic cyc(input bit t, input bit we, input logic [7:0] wd, input bit clr);
        @(negedge clk);
        tick_i = t; ctrl_we_i = we; ctrl_wdata_i = wd; div_clr_i = clr;
        #1;
        s_tmr = tmr_en_o;
        s_wdt = wdt_en_o;
        @(posedge clk);
    endtask

    // Run 2*ratio ticks and check pulse positions on both outputs.
    task automatic measure(input bit asg, input int code, input bit wr, input string req);
        int ratio = asg ? (1 << code) : (1 << (code + 1));
        int first = 0, npul = 0, nraw = 0;
        if (wr) cyc(1'b0, 1'b1, {4'h0, asg, code[2:0]}, 1'b0);
        for (int i = 1; i <= 2 * ratio; i++) begin
            cyc(1'b1, 1'b0, 8'h00, 1'b0);
            if (asg ? s_wdt : s_tmr) begin
                npul++;
                if (first == 0) first = i;
            end
            if (asg ? s_tmr : s_wdt) nraw++;
        end
        check(first == ratio, req, first, ratio);
        check(npul == 2, "R2", npul, 2);
        check(nraw == 2 * ratio, "R5", nraw, 2 * ratio);
    endtask

    // R1: reset value and default ratio.
    task automatic t_reset();
        @(negedge clk); #1;
        check(ctrl_o == 8'hFF, "R1", ctrl_o, 8'hFF);
        measure(1'b1, 7, 1'b0, "R1");
    endtask

    // R3/R4: all sixteen combinations.
    task automatic t_all_ratios();
        for (int a = 0; a < 2; a++)
            for (int c = 0; c < 8; c++)
                measure(a[0], c, 1'b1, a ? "R4" : "R3");
    endtask

    // R6: idle cycles between ticks give no pulses and are not counted.
    task automatic t_gaps();
        int pos = 0, bad = 0;
        cyc(1'b0, 1'b1, 8'h01, 1'b0);   // timer, 1:4
        for (int i = 1; i <= 8; i++) begin
            cyc(1'b0, 1'b0, 8'h00, 1'b0);
            if (s_tmr || s_wdt) bad++;
            cyc(1'b1, 1'b0, 8'h00, 1'b0);
            if (s_tmr && pos == 0) pos = i;
        end
        check(bad == 0, "R6", bad, 0);
        check(pos == 4, "R6", pos, 4);
    endtask

    // R8: clear mid-period restarts the count and suppresses the pulse.
    task automatic t_clear();
        int pos = 0;
        cyc(1'b0, 1'b1, 8'h02, 1'b0);   // timer, 1:8
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 8'h00, 1'b0);
        cyc(1'b1, 1'b0, 8'h00, 1'b1);
        check(s_tmr == 1'b0, "R8", s_tmr, 0);
        check(s_wdt == 1'b1, "R8", s_wdt, 1);
        for (int i = 1; i <= 8; i++) begin
            cyc(1'b1, 1'b0, 8'h00, 1'b0);
            if (s_tmr && pos == 0) pos = i;
        end
        check(pos == 8, "R8", pos, 8);
        @(negedge clk); #1;
        check(ctrl_o == 8'h02, "R8", ctrl_o, 8'h02);
    endtask

    // R7: write with a tick mid-period, including an assignment swap.
    task automatic t_write_restart();
        int pos = 0;
        cyc(1'b0, 1'b1, 8'h0B, 1'b0);   // watchdog, 1:8
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 8'h00, 1'b0);
        cyc(1'b1, 1'b1, 8'h0B, 1'b0);
        check(s_wdt == 1'b0, "R7", s_wdt, 0);
        for (int i = 1; i <= 8; i++) begin
            cyc(1'b1, 1'b0, 8'h00, 1'b0);
            if (s_wdt && pos == 0) pos = i;
        end
        check(pos == 8, "R7", pos, 8);
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 8'h00, 1'b0);
        cyc(1'b1, 1'b1, 8'h02, 1'b0);   // swap to timer, 1:8
        pos = 0;
        for (int i = 1; i <= 8; i++) begin
            cyc(1'b1, 1'b0, 8'h00, 1'b0);
            if (s_tmr && pos == 0) pos = i;
        end
        check(pos == 8, "R7", pos, 8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_all_ratios();
        t_gaps();
        t_clear();
        t_write_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule